// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Front End

This block is the bus interface of an 8192-byte nonvolatile memory peripheral that sits on a microcontroller bus where the low address byte and the data share the same eight lines. While the address strobe is low, the block lets the shared lines and five dedicated high address lines pass through into its address latch. When the strobe rises, the latch freezes the 13-bit address. The top address bit picks one of two independent 4K planes, and the block reports it separately.

Chip enable is active high. The block samples chip enable, the active-low data strobe and the read/write level into the core clock domain. It then turns them into single-cycle read and write request pulses for the array behind it. A read request comes when the data strobe falls with read/write high. A write request comes when the data strobe rises with read/write low, and it carries the byte that was on the bus while the strobe was low. Each request also carries a copy of the latched address taken in the same cycle. A new address phase that starts in the very cycle of a request therefore cannot corrupt the request.

The block drives the shared bus only during the data phase of an enabled read. It raises a standby indication while it is deselected and no address phase is in progress.

Top module: `mabus_front`

## Requirements
- R1: While `addrStbN` is sampled low, `latchedAddr` becomes {`hiAddr`,`adBusIn`} two clock edges after the inputs are applied. Once `addrStbN` is sampled high, `latchedAddr` holds its value whatever the bus and high lines do.
- R2: When `dataStbN` falls while `chipEn` and `readNotWrite` are high, `rdReq` is high for exactly one cycle. It rises at the second clock edge after the fall is applied.
- R3: When `dataStbN` rises while `chipEn` is high and `readNotWrite` is low, `wrReq` is high for exactly one cycle at the second clock edge after the rise. `wrData` then equals the bus byte that was present while the strobe was low.
- R4: With `chipEn` low, no data strobe edge produces `rdReq` or `wrReq`.
- R5: `adBusOe` is high exactly when the previous edge sampled `chipEn` high, `readNotWrite` high and `dataStbN` low. While it is high, `adBusOut` equals `memRdData`; otherwise `adBusOut` is zero.
- R6: `standby` is high exactly when the previous edge sampled `chipEn` low and `addrStbN` high. It is never high together with `adBusOe`.
- R7: In the cycle that `rdReq` or `wrReq` is high, `reqAddr` equals the latched address of the access. `planeSel` equals bit 12 of `reqAddr`.
- R8: After reset, `latchedAddr`, `reqAddr` and `wrData` are zero, no request is pending, the bus is not driven and `standby` is high.
- R9: If a new address phase begins in the same cycle as the data strobe rises to end a write, the write request still carries the old address and data. The latch takes the new address at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous reset, active low |
| adBusIn | input | 8 | Shared address/data lines, inbound |
| adBusOut | output | 8 | Shared address/data lines, outbound read data |
| adBusOe | output | 1 | Output enable for the shared lines |
| hiAddr | input | 5 | Dedicated high address lines (bits 12..8) |
| addrStbN | input | 1 | Address strobe; latch open while low |
| dataStbN | input | 1 | Data strobe, active low |
| chipEn | input | 1 | Chip enable, active high |
| readNotWrite | input | 1 | High selects read, low selects write |
| memRdData | input | 8 | Read data returned by the array |
| latchedAddr | output | 13 | Current content of the address latch |
| rdReq | output | 1 | Single-cycle read request |
| wrReq | output | 1 | Single-cycle write request |
| wrData | output | 8 | Byte captured for the write request |
| reqAddr | output | 13 | Address carried with a request |
| planeSel | output | 1 | Plane chosen by the request address |
| standby | output | 1 | Deselected with no address phase active |

## Verification
A write request and the opening of a new address phase can fall on the same clock edge. The request register and the address latch both update at that edge, so the request could pick up the fresh address, or the latch could miss it. The bench provokes this by raising the data strobe and dropping the address strobe together with a new address on the lines. It then checks that the write pulse reports the old address and byte, and that `latchedAddr` already shows the new address in that same cycle.

// File: rtl/mabus_pkg.sv
package mabus_pkg;

  // Strobes passed from the control half to the datapath half.
  typedef struct packed {
    logic latchOpen;  // address latch transparent this cycle
    logic takeRead;   // a read request is being issued
    logic takeWrite;  // a write request is being issued
    logic driveBus;   // shared lines carry read data
  } mabus_strobes_t;

endpackage

// File: rtl/mabus_ctrl.sv
module mabus_ctrl
  import mabus_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           addrStbN,
  input  logic           dataStbN,
  input  logic           chipEn,
  input  logic           readNotWrite,
  output mabus_strobes_t ctl,
  output logic           rdReq,
  output logic           wrReq,
  output logic           standby,
  output logic           adBusOe
);

  // Sampled copies of the bus controls and the previous data strobe.
  logic asQ, dsQ, ceQ, rwQ, dsPrevQ;
  logic rdEdge, wrEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asQ     <= 1'b1;
      dsQ     <= 1'b1;
      ceQ     <= 1'b0;
      rwQ     <= 1'b1;
      dsPrevQ <= 1'b1;
    end else begin
      asQ     <= addrStbN;
      dsQ     <= dataStbN;
      ceQ     <= chipEn;
      rwQ     <= readNotWrite;
      dsPrevQ <= dsQ;
    end
  end

  // Falling data strobe starts a read; rising data strobe ends a write.
  always_comb begin
    rdEdge = dsPrevQ && !dsQ && ceQ && rwQ;
    wrEdge = !dsPrevQ && dsQ && ceQ && !rwQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdReq <= 1'b0;
      wrReq <= 1'b0;
    end else begin
      rdReq <= rdEdge;
      wrReq <= wrEdge;
    end
  end

  always_comb begin
    ctl.latchOpen = !asQ;
    ctl.takeRead  = rdEdge;
    ctl.takeWrite = wrEdge;
    ctl.driveBus  = ceQ && rwQ && !dsQ;
  end

  assign adBusOe = ctl.driveBus;
  assign standby = !ceQ && asQ;

endmodule

// File: rtl/mabus_datapath.sv
module mabus_datapath
  import mabus_pkg::*;
#(
  parameter int LO_W = 8,
  parameter int HI_W = 5,
  localparam int ADDR_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  mabus_strobes_t    ctl,
  input  logic [LO_W-1:0]   adBusIn,
  input  logic [HI_W-1:0]   hiAddr,
  input  logic [LO_W-1:0]   memRdData,
  output logic [ADDR_W-1:0] latchedAddr,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [LO_W-1:0]   wrData,
  output logic [LO_W-1:0]   adBusOut
);

  logic [LO_W-1:0]   loQ, loPrevQ;
  logic [HI_W-1:0]   hiQ;
  logic [ADDR_W-1:0] addrQ, reqAddrQ;
  logic [LO_W-1:0]   wrDataQ;

  // Input sampling, aligned with the control sampling stage.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loQ     <= '0;
      loPrevQ <= '0;
      hiQ     <= '0;
    end else begin
      loQ     <= adBusIn;
      loPrevQ <= loQ;
      hiQ     <= hiAddr;
    end
  end

  // Address latch: follows the lines while open, holds otherwise.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addrQ <= '0;
    else if (ctl.latchOpen) addrQ <= {hiQ, loQ};
  end

  // Request address is taken from the latch before any new address lands.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqAddrQ <= '0;
    else if (ctl.takeRead || ctl.takeWrite) reqAddrQ <= addrQ;
  end

  // Write byte is the one seen while the data strobe was still low.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrDataQ <= '0;
    else if (ctl.takeWrite) wrDataQ <= loPrevQ;
  end

  assign latchedAddr = addrQ;
  assign reqAddr     = reqAddrQ;
  assign wrData      = wrDataQ;
  assign adBusOut    = ctl.driveBus ? memRdData : '0;

endmodule

// File: rtl/mabus_front.sv
module mabus_front
  import mabus_pkg::*;
#(
  parameter int LO_W = 8,
  parameter int HI_W = 5,
  localparam int ADDR_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LO_W-1:0]   adBusIn,
  output logic [LO_W-1:0]   adBusOut,
  output logic              adBusOe,
  input  logic [HI_W-1:0]   hiAddr,
  input  logic              addrStbN,
  input  logic              dataStbN,
  input  logic              chipEn,
  input  logic              readNotWrite,
  input  logic [LO_W-1:0]   memRdData,
  output logic [ADDR_W-1:0] latchedAddr,
  output logic              rdReq,
  output logic              wrReq,
  output logic [LO_W-1:0]   wrData,
  output logic [ADDR_W-1:0] reqAddr,
  output logic              planeSel,
  output logic              standby
);

  mabus_strobes_t ctl;

  mabus_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .addrStbN     (addrStbN),
    .dataStbN     (dataStbN),
    .chipEn       (chipEn),
    .readNotWrite (readNotWrite),
    .ctl          (ctl),
    .rdReq        (rdReq),
    .wrReq        (wrReq),
    .standby      (standby),
    .adBusOe      (adBusOe)
  );

  mabus_datapath #(.LO_W(LO_W), .HI_W(HI_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .adBusIn     (adBusIn),
    .hiAddr      (hiAddr),
    .memRdData   (memRdData),
    .latchedAddr (latchedAddr),
    .reqAddr     (reqAddr),
    .wrData      (wrData),
    .adBusOut    (adBusOut)
  );

  // The top address bit selects the plane.
  assign planeSel = reqAddr[ADDR_W-1];

endmodule

// File: rtl/mabus_front_chk.sv
module mabus_front_chk (
  input logic        clk,
  input logic        rstN,
  input logic        addrStbN,
  input logic        dataStbN,
  input logic        chipEn,
  input logic        readNotWrite,
  input logic        adBusOe,
  input logic        rdReq,
  input logic        wrReq,
  input logic        standby,
  input logic [12:0] latchedAddr
);

  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq); // R2

  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |=> !wrReq); // R3

  AST_REQ_NEEDS_CE: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq || wrReq) |-> $past(chipEn, 2)); // R4

  AST_OE_READ_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    adBusOe |-> ($past(chipEn) && $past(readNotWrite) && !$past(dataStbN))); // R5

  AST_STANDBY_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    standby |-> !adBusOe); // R6

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $past(addrStbN, 2) |-> $stable(latchedAddr)); // R1

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(rdReq && wrReq)); // R2

endmodule

bind mabus_front mabus_front_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .addrStbN     (addrStbN),
  .dataStbN     (dataStbN),
  .chipEn       (chipEn),
  .readNotWrite (readNotWrite),
  .adBusOe      (adBusOe),
  .rdReq        (rdReq),
  .wrReq        (wrReq),
  .standby      (standby),
  .latchedAddr  (latchedAddr)
);

// File: tb/tb_mabus_front.sv
module tb_mabus_front;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  adBusIn = '0;
  logic [7:0]  adBusOut;
  logic        adBusOe;
  logic [4:0]  hiAddr = '0;
  logic        addrStbN = 1'b1;
  logic        dataStbN = 1'b1;
  logic        chipEn = 1'b0;
  logic        readNotWrite = 1'b1;
  logic [7:0]  memRdData;
  logic [12:0] latchedAddr;
  logic        rdReq, wrReq;
  logic [7:0]  wrData;
  logic [12:0] reqAddr;
  logic        planeSel, standby;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] memModel(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction

  // Array stand-in: read data follows the latched address.
  assign memRdData = memModel(latchedAddr);

  mabus_front dut (
    .clk(clk), .rstN(rstN), .adBusIn(adBusIn), .adBusOut(adBusOut),
    .adBusOe(adBusOe), .hiAddr(hiAddr), .addrStbN(addrStbN),
    .dataStbN(dataStbN), .chipEn(chipEn), .readNotWrite(readNotWrite),
    .memRdData(memRdData), .latchedAddr(latchedAddr), .rdReq(rdReq),
    .wrReq(wrReq), .wrData(wrData), .reqAddr(reqAddr),
    .planeSel(planeSel), .standby(standby)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // One complete bus cycle: address phase, then data phase.
  task automatic busCycle(input logic [12:0] a, input logic [7:0] d,
                          input bit ce, input bit rd);
    addrStbN = 1'b0; adBusIn = a[7:0]; hiAddr = a[12:8];
    chipEn = ce; readNotWrite = rd; dataStbN = 1'b1;
    tick();
    chk("R5 no drive in address phase", adBusOe, 0);
    tick();
    chk("R1 latch follows lines", latchedAddr, a);
    addrStbN = 1'b1;
    tick();
    chk("R6 standby after address phase", standby, !ce);
    adBusIn = rd ? 8'h00 : d;
    hiAddr = ~a[12:8];
    tick();
    tick();
    chk("R1 latch holds", latchedAddr, a);
    dataStbN = 1'b0;
    tick();
    chk("R5 oe on read phase", adBusOe, ce && rd);
    chk("R5 read data on bus", adBusOut, (ce && rd) ? memModel(a) : 8'h00);
    chk("R2 no early read pulse", rdReq, 0);
    tick();
    chk("R2 R4 read pulse", rdReq, ce && rd);
    if (ce && rd) begin
      chk("R7 read address", reqAddr, a);
      chk("R7 plane on read", planeSel, a[12]);
    end
    tick();
    chk("R2 read pulse single", rdReq, 0);
    dataStbN = 1'b1;
    tick();
    chk("R5 oe released", adBusOe, 0);
    chk("R3 no early write pulse", wrReq, 0);
    tick();
    chk("R3 R4 write pulse", wrReq, ce && !rd);
    if (ce && !rd) begin
      chk("R3 write data", wrData, d);
      chk("R7 write address", reqAddr, a);
      chk("R7 plane on write", planeSel, a[12]);
    end
    tick();
    chk("R3 write pulse single", wrReq, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [12:0] oldA, newA;
    logic [7:0] lo;
    tick(); tick();
    rstN = 1'b1;
    tick();
    // R8 reset state
    chk("R8 latch reset", latchedAddr, 0);
    chk("R8 reqAddr reset", reqAddr, 0);
    chk("R8 wrData reset", wrData, 0);
    chk("R8 no read", rdReq, 0);
    chk("R8 no write", wrReq, 0);
    chk("R8 bus idle", adBusOe, 0);
    chk("R8 standby", standby, 1);

    for (int h = 0; h < 32; h++) begin
      for (int p = 0; p < 5; p++) begin
        case (p)
          0: lo = 8'h00;
          1: lo = 8'hFF;
          2: lo = 8'hA5;
          3: lo = 8'h5A;
          default: lo = 8'(h * 7 + 3);
        endcase
        for (int m = 0; m < 4; m++)
          busCycle({5'(h), lo}, ~lo ^ 8'(h), m[1], m[0]);
      end
    end

    // R9: write ends in the same cycle a new address phase opens.
    oldA = 13'h1234; newA = 13'h0ABC;
    addrStbN = 1'b0; adBusIn = oldA[7:0]; hiAddr = oldA[12:8];
    chipEn = 1'b1; readNotWrite = 1'b0;
    tick(); tick();
    addrStbN = 1'b1;
    tick();
    adBusIn = 8'h3C;
    tick();
    dataStbN = 1'b0;
    tick(); tick(); tick();
    dataStbN = 1'b1; addrStbN = 1'b0; adBusIn = newA[7:0]; hiAddr = newA[12:8];
    tick();
    chk("R9 no pulse yet", wrReq, 0);
    tick();
    chk("R9 write pulse", wrReq, 1);
    chk("R9 old address kept", reqAddr, oldA);
    chk("R9 old data kept", wrData, 8'h3C);
    chk("R9 new address latched", latchedAddr, newA);
    tick();
    chk("R9 single pulse", wrReq, 0);
    addrStbN = 1'b1; chipEn = 1'b0;
    tick(); tick();
    chk("R6 standby when deselected", standby, 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule